// File: doc/BRIEF.md
# Programmable Six-Mode Down-Counter Channel

This block is a single channel of a programmable interval timer. A 16-bit down counter advances once for every cycle in which the count enable is high. It counts either in plain binary (0 to 65535) or as four packed decimal digits (0 to 9999). Six operating modes shape the output pin from the count and from a gate input:
- a terminal-count flag
- a retriggerable one-shot
- a divide-by-N rate generator
- a square-wave generator
- a software-started strobe
- a gate-started strobe

A host-side decoder, which is not part of this block, selects the mode with a mode-write strobe and supplies count values. It uses a count-written strobe once the whole value is present, and a first-byte strobe when the first half of a two-byte count arrives. The current count is always visible on a readback port. Every pin is a plain control or status signal. There is no streaming data path, so no valid/ready handshake or back-pressure applies.

A loaded count of zero is treated as the largest count: 65536 in binary, 10000 in decimal. The gate input is sampled only on count-enable cycles. A gate rising edge is a low sample followed by a high sample.

Top module: `ptimer_channel`

## Requirements
- R1: After reset, the output pin is low and the readback count is 0.
- R2: The count changes only on enabled cycles. In binary it decrements modulo 65536. In decimal (bcd_sel=1), each 4-bit digit borrows from the next, so 0x0100 becomes 0x0099 and 0 becomes 0x9999. A loaded 0 therefore acts as 65536 or 10000 counts.
- R3: In mode 0 (mode_sel=0), the output drops on the first enabled cycle after a count is written. That cycle loads the count. The output rises on the enabled cycle that takes the count from 1 to 0. It stays high until the next load, and counting continues past 0.
- R4: In mode 0, an enabled cycle with first_byte_wr high, and every later cycle until count_wr, performs no decrement. count_wr then restarts counting from the new value.
- R5: In mode 1, an enabled cycle that sees a gate rising edge loads the count and drives the output low. The output returns high when the count reaches 0, after N enabled cycles. A new rising edge during the pulse reloads the full count.
- R6: In mode 2, the output is low for one enabled cycle in every N, where N is at least 2. Counting starts on the first enabled cycle with the gate high after a count is written.
- R7: In modes 2 and 3, an enabled cycle with the gate low forces the output high and stops counting. The next enabled cycle with the gate high restarts from the full count.
- R8: In mode 3, an even N gives N/2 cycles high and N/2 low. An odd N gives (N+1)/2 cycles high and (N-1)/2 low, starting high.
- R9: In mode 4, the output pulses low for exactly one enabled cycle when the count reaches 0. That happens N enabled cycles after the load cycle. A low gate halts decrementing.
- R10: In mode 5, a gate rising edge loads the count, and the output pulses low for one enabled cycle when the count reaches 0. A rising edge during counting reloads the full count and postpones the pulse.
- R11: A mode write has the following effects. It clears the count to 0 and discards any count written earlier. It drives the output low for mode 0 and high for every other mode. Codes 6 and 7 act as modes 2 and 3.
- R12: In modes 2 and 3, a count written while running leaves the current period unchanged and applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable: one counter clock per cycle high |
| gate_in | input | 1 | Gate / trigger input |
| mode_wr | input | 1 | Mode-set strobe |
| mode_sel | input | 3 | Mode code 0..7 |
| bcd_sel | input | 1 | 1 selects decimal counting |
| count_wr | input | 1 | Full count value written |
| first_byte_wr | input | 1 | First byte of a two-byte count written |
| count_val | input | 16 | New count value |
| out_pin | output | 1 | Channel output |
| count_rd | output | 16 | Current count |

## Verification
The properties assume the following about the inputs:
- Every count written while decimal counting is selected is a valid four-digit decimal value.
- mode_wr and count_wr are never raised in the same cycle.
- Periodic modes receive counts of at least 2.

The directed stimulus writes only valid decimal values in decimal mode and issues mode writes and count writes in separate cycles. It also keeps rate and square-wave counts at 2 or above. As a result, the checks on the digit range, the gate-forced high output and the single-cycle strobes see only legal stimulus.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  localparam int DIGITS_DEF = 4;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ptc_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic ptc_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return ptc_mode_e'({1'b0, code[1:0]});
    return ptc_mode_e'(code);
  endfunction
endpackage

// File: rtl/ptc_decr.sv
`timescale 1ns/1ps
// subtracts a step of 1..3 in binary or packed decimal, wrapping at zero
module ptc_decr #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic [1:0]          step,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] res
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] dec_res;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [4:0] sub;
    logic [4:0] d;
    logic       bo;
    if (g == 0) begin : g_lsd
      assign sub = {3'b000, step};
    end else begin : g_hi
      assign sub = {4'b0000, g_dig[g-1].bo};
    end
    assign d  = {1'b0, val[4*g +: 4]};
    assign bo = (d < sub);
    assign dec_res[4*g +: 4] = bo ? 4'(d + 5'd10 - sub) : 4'(d - sub);
  end

  assign res = bcd ? dec_res : (val - {{(W-2){1'b0}}, step});
endmodule

// File: rtl/ptc_gate_sync.sv
`timescale 1ns/1ps
// samples the gate on counter-clock cycles and flags a low-to-high change
module ptc_gate_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    gate_q <= 1'b0;
    else if (tick) gate_q <= gate;
  end

  assign rise = tick & gate & ~gate_q;
endmodule

// File: rtl/ptimer_channel.sv
`timescale 1ns/1ps
module ptimer_channel
  import ptc_pkg::*;
#(
  parameter int DIGITS = ptc_pkg::DIGITS_DEF,
  localparam int CNT_W = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  input  logic             count_wr,
  input  logic             first_byte_wr,
  input  logic [CNT_W-1:0] count_val,
  output logic             out_pin,
  output logic [CNT_W-1:0] count_rd
);
  ptc_mode_e        mode_q;
  logic             bcd_q;
  logic [CNT_W-1:0] cnt_q, reload_q, dec_val;
  logic             out_r, loaded_q, load_pend_q, running_q, halt_q;
  logic             gate_rise;
  logic [1:0]       step_sel;
  logic             at_end, at_two;

  ptc_gate_sync u_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_en),
    .gate (gate_in),
    .rise (gate_rise)
  );

  // square mode steps by two, with a 1 or 3 step on odd counts
  always_comb begin
    step_sel = 2'd1;
    if (mode_q == M_SQUARE)
      step_sel = cnt_q[0] ? (out_r ? 2'd1 : 2'd3) : 2'd2;
  end

  ptc_decr #(.DIGITS(DIGITS)) u_decr (
    .val (cnt_q),
    .step(step_sel),
    .bcd (bcd_q),
    .res (dec_val)
  );

  assign at_end = (cnt_q == {{(CNT_W-2){1'b0}}, step_sel});
  assign at_two = (cnt_q == {{(CNT_W-2){1'b0}}, 2'd2});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= M_TERM;
      bcd_q       <= 1'b0;
      cnt_q       <= '0;
      reload_q    <= '0;
      out_r       <= 1'b0;
      loaded_q    <= 1'b0;
      load_pend_q <= 1'b0;
      running_q   <= 1'b0;
      halt_q      <= 1'b0;
    end else if (mode_wr) begin
      mode_q      <= fold_mode(mode_sel);
      bcd_q       <= bcd_sel;
      cnt_q       <= '0;
      loaded_q    <= 1'b0;
      load_pend_q <= 1'b0;
      running_q   <= 1'b0;
      halt_q      <= 1'b0;
      out_r       <= (mode_sel != 3'd0);
    end else begin
      if (count_wr) begin
        reload_q    <= count_val;
        loaded_q    <= 1'b1;
        load_pend_q <= 1'b1;
        halt_q      <= 1'b0;
      end else if (first_byte_wr && mode_q == M_TERM) begin
        halt_q <= 1'b1;
      end

      if (tick_en) begin
        case (mode_q)
          M_TERM: begin
            if (load_pend_q) begin
              cnt_q <= reload_q;
              out_r <= 1'b0;
              if (!count_wr) load_pend_q <= 1'b0;
            end else if (loaded_q && !halt_q && !first_byte_wr) begin
              cnt_q <= dec_val;
              if (at_end) out_r <= 1'b1;
            end
          end
          M_ONESHOT: begin
            if (gate_rise && loaded_q) begin
              cnt_q     <= reload_q;
              out_r     <= 1'b0;
              running_q <= 1'b1;
            end else if (running_q) begin
              cnt_q <= dec_val;
              if (at_end) begin
                out_r     <= 1'b1;
                running_q <= 1'b0;
              end
            end
          end
          M_RATE, M_SQUARE: begin
            if (!gate_in) begin
              out_r     <= 1'b1;
              running_q <= 1'b0;
            end else if (!running_q) begin
              if (loaded_q) begin
                cnt_q     <= reload_q;
                out_r     <= 1'b1;
                running_q <= 1'b1;
              end
            end else if (mode_q == M_RATE) begin
              if (at_end) begin
                cnt_q <= reload_q;
                out_r <= 1'b1;
              end else begin
                cnt_q <= dec_val;
                out_r <= !at_two;
              end
            end else begin
              if (at_end) begin
                cnt_q <= reload_q;
                out_r <= !out_r;
              end else begin
                cnt_q <= dec_val;
              end
            end
          end
          M_SWSTROBE: begin
            if (!out_r) out_r <= 1'b1;
            if (load_pend_q) begin
              cnt_q     <= reload_q;
              running_q <= 1'b1;
              if (!count_wr) load_pend_q <= 1'b0;
            end else if (running_q && gate_in) begin
              cnt_q <= dec_val;
              if (at_end) begin
                out_r     <= 1'b0;
                running_q <= 1'b0;
              end
            end
          end
          M_HWSTROBE: begin
            if (!out_r) out_r <= 1'b1;
            if (gate_rise && loaded_q) begin
              cnt_q     <= reload_q;
              running_q <= 1'b1;
            end else if (running_q) begin
              cnt_q <= dec_val;
              if (at_end) begin
                out_r     <= 1'b0;
                running_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign out_pin  = out_r;
  assign count_rd = cnt_q;
endmodule

// File: rtl/ptimer_channel_chk.sv
`timescale 1ns/1ps
module ptimer_channel_chk #(
  parameter int DIGITS = 4,
  localparam int CNT_W = 4 * DIGITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             gate_in,
  input logic             mode_wr,
  input logic [2:0]       mode_sel,
  input logic             out_pin,
  input logic [CNT_W-1:0] count_rd,
  input logic             bcd_q,
  input logic [2:0]       mode_q,
  input logic             load_pend_q
);
  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (count_rd[4*i +: 4] > 4'd9) digits_ok = 1'b0;
  end

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !mode_wr) |=> $stable(count_rd));

  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_q |-> digits_ok);

  p_term_stays_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out_pin && !mode_wr && !(tick_en && load_pend_q)) |=> out_pin);

  p_gate_forces_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd2 || mode_q == 3'd3) && tick_en && !gate_in && !mode_wr) |=> out_pin);

  p_strobe_one_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !out_pin && tick_en && !mode_wr) |=> out_pin);

  p_mode_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_sel != 3'd0) |=> (out_pin && count_rd == '0));
endmodule

bind ptimer_channel ptimer_channel_chk #(.DIGITS(DIGITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .gate_in    (gate_in),
  .mode_wr    (mode_wr),
  .mode_sel   (mode_sel),
  .out_pin    (out_pin),
  .count_rd   (count_rd),
  .bcd_q      (bcd_q),
  .mode_q     (mode_q),
  .load_pend_q(load_pend_q)
);

// File: tb/ptimer_channel_tb.sv
`timescale 1ns/1ps
module ptimer_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        gate_in = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        bcd_sel = 1'b0;
  logic        count_wr = 1'b0;
  logic        first_byte_wr = 1'b0;
  logic [15:0] count_val = 16'd0;
  logic        out_pin;
  logic [15:0] count_rd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptimer_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .bcd_sel(bcd_sel),
    .count_wr(count_wr), .first_byte_wr(first_byte_wr), .count_val(count_val),
    .out_pin(out_pin), .count_rd(count_rd)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m, input logic b);
    mode_sel = m; bcd_sel = b; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic write_count(input logic [15:0] v);
    count_val = v; count_wr = 1'b1;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out after reset", out_pin, 0);
    check("R1 count after reset", count_rd, 0);
  endtask

  task automatic t_term_binary;
    set_mode(3'd0, 1'b0);
    check("R11 mode0 out low", out_pin, 0);
    write_count(16'd3);
    step(3);
    check("R3 count at 1", count_rd, 1);
    check("R3 out low before end", out_pin, 0);
    step(1);
    check("R3 out high at end", out_pin, 1);
    step(1);
    check("R2 binary wrap", count_rd, 65535);
    check("R3 out stays high", out_pin, 1);
    tick_en = 1'b0;
    step(4);
    check("R2 hold without enable", count_rd, 65535);
    tick_en = 1'b1;
  endtask

  task automatic t_term_halt;
    set_mode(3'd0, 1'b0);
    write_count(16'd10);
    step(3);
    check("R4 before halt", count_rd, 8);
    first_byte_wr = 1'b1;
    step(1);
    first_byte_wr = 1'b0;
    step(4);
    check("R4 halted count", count_rd, 8);
    write_count(16'd4);
    step(1);
    check("R4 new value loaded", count_rd, 4);
    step(3);
    check("R4 out low at 1", out_pin, 0);
    step(1);
    check("R4 out high at end", out_pin, 1);
  endtask

  task automatic t_term_bcd;
    set_mode(3'd0, 1'b1);
    write_count(16'h0100);
    step(2);
    check("R2 bcd borrow", count_rd, 16'h0099);
    write_count(16'h0000);
    step(2);
    check("R2 bcd zero wraps", count_rd, 16'h9999);
    step(9998);
    check("R2 bcd max count not yet", out_pin, 0);
    check("R2 bcd count at 1", count_rd, 1);
    step(1);
    check("R2 bcd 10000 counts", out_pin, 1);
  endtask

  task automatic t_oneshot;
    gate_in = 1'b0;
    step(1);
    set_mode(3'd1, 1'b0);
    write_count(16'd4);
    check("R5 idle high", out_pin, 1);
    gate_in = 1'b1;
    step(4);
    check("R5 low during pulse", out_pin, 0);
    check("R5 count at 1", count_rd, 1);
    step(1);
    check("R5 high after N", out_pin, 1);
    gate_in = 1'b0;
    step(1);
    gate_in = 1'b1;
    step(2);
    gate_in = 1'b0;
    step(1);
    gate_in = 1'b1;
    step(4);
    check("R5 retrigger extends pulse", out_pin, 0);
    step(1);
    check("R5 high after retrigger", out_pin, 1);
  endtask

  task automatic t_rate;
    gate_in = 1'b1;
    set_mode(3'd2, 1'b0);
    write_count(16'd3);
    step(2);
    check("R6 high before pulse", out_pin, 1);
    step(1);
    check("R6 low pulse", out_pin, 0);
    step(1);
    check("R6 back high", out_pin, 1);
    check("R6 reloaded", count_rd, 3);
    write_count(16'd5);
    step(1);
    check("R12 current period unchanged", out_pin, 0);
    step(4);
    check("R12 new period high", out_pin, 1);
    check("R12 new period count", count_rd, 2);
    step(1);
    check("R12 new period pulse", out_pin, 0);
    gate_in = 1'b0;
    step(1);
    check("R7 gate low forces high", out_pin, 1);
    step(3);
    check("R7 stays high", out_pin, 1);
    gate_in = 1'b1;
    step(4);
    check("R7 restart count", count_rd, 2);
    step(1);
    check("R7 restart pulse", out_pin, 0);
  endtask

  task automatic t_square(input logic [15:0] n, input logic [7:0] pat, input string tag);
    gate_in = 1'b1;
    set_mode(3'd3, 1'b0);
    write_count(n);
    for (int i = 0; i < 8; i++) begin
      step(1);
      check(tag, out_pin, pat[7-i]);
    end
  endtask

  task automatic t_swstrobe;
    gate_in = 1'b1;
    set_mode(3'd4, 1'b0);
    check("R11 mode4 out high", out_pin, 1);
    write_count(16'd3);
    step(3);
    check("R9 before strobe", out_pin, 1);
    step(1);
    check("R9 strobe low", out_pin, 0);
    step(1);
    check("R9 strobe one cycle", out_pin, 1);
    gate_in = 1'b0;
    write_count(16'd3);
    step(5);
    check("R9 gate low inhibits", count_rd, 3);
    gate_in = 1'b1;
    step(2);
    check("R9 resumes", count_rd, 1);
    step(1);
    check("R9 strobe after resume", out_pin, 0);
  endtask

  task automatic t_hwstrobe;
    gate_in = 1'b0;
    step(1);
    set_mode(3'd5, 1'b0);
    write_count(16'd3);
    step(3);
    check("R10 no start without edge", count_rd, 0);
    gate_in = 1'b1;
    step(3);
    check("R10 counting", count_rd, 1);
    step(1);
    check("R10 strobe low", out_pin, 0);
    step(1);
    check("R10 strobe one cycle", out_pin, 1);
    gate_in = 1'b0;
    step(1);
    gate_in = 1'b1;
    step(2);
    gate_in = 1'b0;
    step(1);
    gate_in = 1'b1;
    step(1);
    check("R10 retrigger reloads", count_rd, 3);
    check("R10 retrigger postpones strobe", out_pin, 1);
    step(3);
    check("R10 strobe after retrigger", out_pin, 0);
  endtask

  task automatic t_alias;
    gate_in = 1'b1;
    set_mode(3'd6, 1'b0);
    write_count(16'd3);
    step(2);
    check("R11 code6 high", out_pin, 1);
    step(1);
    check("R11 code6 acts as rate", out_pin, 0);
    set_mode(3'd4, 1'b0);
    check("R11 mode write clears count", count_rd, 0);
    step(5);
    check("R11 old count discarded", count_rd, 0);
    check("R11 no strobe", out_pin, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_term_binary();
    t_term_halt();
    t_term_bcd();
    t_oneshot();
    t_rate();
    t_square(16'd4, 8'b1100_1100, "R8 even square");
    t_square(16'd5, 8'b1110_0111, "R8 odd square");
    t_swstrobe();
    t_hwstrobe();
    t_alias();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule